// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Target with Page Buffer

This block behaves as a small serial EEPROM of 1024 bytes on a two-wire bus. A fast system clock samples the bus clock and data lines through a short synchronizer. The block recognises START and STOP conditions and decodes a control byte that carries a device code, block-select bits and a read/write flag. On a write, the next byte completes a 10-bit word address.

Write data is gathered in a 16-byte page buffer and copied into the storage array only after the closing STOP. A timed programming interval follows, during which the target stays silent on the bus. Reads stream bytes from the current address and step the address after every byte the master acknowledges. A repeated START turns an address-setting write into a random read.

The data line is open-drain. The block only ever asks for it to be pulled low, through a single enable output.

Top module: `i2c_eeprom_target`

## Requirements
- R1: After reset, and at all times outside an acknowledge or read-data slot, the pull-down enable is 0. Bus activity that does not begin with a START gets no response.
- R2: A control byte is acknowledged only when its upper four bits equal 1010. With any other code the target stays silent for the rest of that transfer, including later bytes, until the next START.
- R3: After each byte received while addressed, the target pulls SDA low for the whole high period of the ninth clock and releases it after that clock falls.
- R4: The word address is 10 bits: control-byte bits [2:1] supply address bits [9:8] and the address byte supplies bits [7:0]. Control-byte bit 0 selects the direction, with 1 meaning read.
- R5: Read data is sent MSB first and SDA changes only while SCL is low. After every byte the master acknowledges, the address advances by one modulo 1024.
- R6: When the master does not acknowledge a read byte, the target releases SDA and sends nothing more until the next START.
- R7: A START seen in the middle of a transfer abandons it, discards any partly received byte and restarts control-byte decoding. This allows a write of the address followed by a repeated START and a read.
- R8: Write data bytes fill page slots starting at the address's low four bits and stepping modulo 16. When more than 16 bytes arrive, each later byte replaces the one 16 places before it, so the last 16 are kept.
- R9: Memory is written only on a STOP that ends a write holding at least one complete data byte, and only at the page given by address bits [9:4]. A STOP after only the address, or after a partial data byte, changes nothing and starts no programming interval.
- R10: For BUSY_CYCLES system clocks after a commit, the target acknowledges nothing, control bytes included. After that interval it responds normally again.
- R11: SDA falling while SCL is high is a START and SDA rising while SCL is high is a STOP. A STOP ends any transfer and releases SDA.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than the bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen on the pin |
| sda_i | input | 1 | Bus data line as seen on the pin |
| sda_pull_o | output | 1 | 1 pulls the open-drain data line low |

## Verification
The situation hardest to reach from the pins is the overwrite inside the page buffer. It only shows up once more than 16 data bytes arrive in a single write that starts in the middle of a page. The bench sends 20 bytes starting at offset 5, then reads the page back and compares it with a model that replays the modulo-16 slot rule. The silent programming interval is reached by issuing a control byte within a few hundred clocks of each committing STOP. The contrasting case, where no interval starts, is reached by a STOP after only an address or after a partial byte, followed at once by an acknowledged control byte.

// File: rtl/eep_pkg.sv
package eep_pkg;

  // protocol phase of the target
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_CTRL,
    PH_WADDR,
    PH_WDATA,
    PH_READ
  } phase_t;

  localparam logic [3:0] EEP_DEV_CODE = 4'b1010;

  // bit counter step: 0..7 data bits, 8 = ninth-clock low phase, 9 = ninth clock seen
  function automatic logic [3:0] bit_next(input logic [3:0] b);
    return b + 4'd1;
  endfunction

endpackage

// File: rtl/eep_bus_sync.sv
module eep_bus_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic ev_scl_rise,
  output logic ev_scl_fall,
  output logic ev_start,
  output logic ev_stop
);

  logic [STAGES-1:0] scl_pipe;
  logic [STAGES-1:0] sda_pipe;
  logic scl_d;
  logic sda_d;
  logic scl_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_d    <= 1'b1;
      sda_d    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
      sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
      scl_d    <= scl_s;
      sda_d    <= sda_s;
    end
  end

  assign scl_s = scl_pipe[STAGES-1];
  assign sda_s = sda_pipe[STAGES-1];

  assign ev_scl_rise = scl_s & ~scl_d;
  assign ev_scl_fall = ~scl_s & scl_d;
  assign ev_start    = scl_s & scl_d & sda_d & ~sda_s;
  assign ev_stop     = scl_s & scl_d & ~sda_d & sda_s;

endmodule

// File: rtl/eep_page_buf.sv
module eep_page_buf #(
  parameter int PAGE_AW = 4,
  parameter int DW      = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr,
  input  logic [PAGE_AW-1:0] base,
  input  logic               push,
  input  logic [DW-1:0]      din,
  input  logic [PAGE_AW-1:0] rd_slot,
  output logic [DW-1:0]      rd_data,
  output logic [(1<<PAGE_AW)-1:0] valid,
  output logic               any_valid
);

  localparam int SLOTS = 1 << PAGE_AW;

  logic [DW-1:0]      slot_q [SLOTS];
  logic [SLOTS-1:0]   valid_q;
  logic [PAGE_AW-1:0] wptr_q;

  // write slot wraps inside the page
  function automatic logic [PAGE_AW-1:0] slot_step(input logic [PAGE_AW-1:0] p);
    return p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
      wptr_q  <= '0;
    end else if (clr) begin
      valid_q <= '0;
      wptr_q  <= base;
    end else if (push) begin
      valid_q[wptr_q] <= 1'b1;
      wptr_q          <= slot_step(wptr_q);
    end
  end

  generate
    for (genvar g = 0; g < SLOTS; g++) begin : g_slot
      always_ff @(posedge clk) begin
        if (push && !clr && wptr_q == PAGE_AW'(g))
          slot_q[g] <= din;
      end
    end
  endgenerate

  assign rd_data   = slot_q[rd_slot];
  assign valid     = valid_q;
  assign any_valid = |valid_q;

endmodule

// File: rtl/eep_store.sv
module eep_store #(
  parameter int MEM_AW      = 10,
  parameter int PAGE_AW     = 4,
  parameter int DW          = 8,
  parameter int BUSY_CYCLES = 5000
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      commit,
  input  logic [MEM_AW-PAGE_AW-1:0] commit_page,
  input  logic [(1<<PAGE_AW)-1:0]   buf_valid,
  input  logic [DW-1:0]             buf_data,
  output logic [PAGE_AW-1:0]        buf_slot,
  input  logic [MEM_AW-1:0]         rd_addr,
  output logic [DW-1:0]             rd_data,
  output logic                      busy
);

  localparam int WORDS = 1 << MEM_AW;
  localparam int SLOTS = 1 << PAGE_AW;
  localparam int PG_W  = MEM_AW - PAGE_AW;
  localparam int CNT_W = $clog2(BUSY_CYCLES + 1);

  logic [DW-1:0]      mem [WORDS];
  logic               walking_q;
  logic [PAGE_AW-1:0] walk_q;
  logic [PG_W-1:0]    page_q;
  logic [CNT_W-1:0]   busy_cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      walking_q  <= 1'b0;
      walk_q     <= '0;
      page_q     <= '0;
      busy_cnt_q <= '0;
    end else if (commit) begin
      walking_q  <= 1'b1;
      walk_q     <= '0;
      page_q     <= commit_page;
      busy_cnt_q <= CNT_W'(BUSY_CYCLES);
    end else begin
      if (busy_cnt_q != '0)
        busy_cnt_q <= busy_cnt_q - 1'b1;
      if (walking_q) begin
        walk_q <= walk_q + 1'b1;
        if (walk_q == PAGE_AW'(SLOTS - 1))
          walking_q <= 1'b0;
      end
    end
  end

  // one slot per cycle, only the slots that received data
  always_ff @(posedge clk) begin
    if (walking_q && buf_valid[walk_q])
      mem[{page_q, walk_q}] <= buf_data;
  end

  assign buf_slot = walk_q;
  assign rd_data  = mem[rd_addr];
  assign busy     = busy_cnt_q != '0;

endmodule

// File: rtl/i2c_eeprom_target.sv
module i2c_eeprom_target #(
  parameter int         MEM_AW      = 10,
  parameter int         PAGE_AW     = 4,
  parameter int         BUSY_CYCLES = 5000,
  parameter int         SYNC_STAGES = 2,
  parameter logic [3:0] DEV_CODE    = eep_pkg::EEP_DEV_CODE
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_pull_o
);
  import eep_pkg::*;

  localparam int BLK_W = MEM_AW - 8;
  localparam int PG_W  = MEM_AW - PAGE_AW;
  localparam int SLOTS = 1 << PAGE_AW;

  function automatic logic [MEM_AW-1:0] join_addr(input logic [BLK_W-1:0] blk,
                                                   input logic [7:0] lo);
    return {blk, lo};
  endfunction

  function automatic logic [MEM_AW-1:0] addr_step(input logic [MEM_AW-1:0] a);
    return a + 1'b1;
  endfunction

  function automatic logic [PG_W-1:0] page_of(input logic [MEM_AW-1:0] a);
    return a[MEM_AW-1:PAGE_AW];
  endfunction

  // bus events, brought out by name
  logic sda_s, ev_scl_rise, ev_scl_fall, ev_start, ev_stop;

  eep_bus_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .sda_s      (sda_s),
    .ev_scl_rise(ev_scl_rise),
    .ev_scl_fall(ev_scl_fall),
    .ev_start   (ev_start),
    .ev_stop    (ev_stop)
  );

  phase_t             phase_q;
  logic [3:0]         bit_q;
  logic [7:0]         rx_q;
  logic [7:0]         tx_q;
  logic [MEM_AW-1:0]  addr_q;
  logic [BLK_W-1:0]   blk_q;
  logic               rw_q;
  logic               ack_q;
  logic               pull_q;

  logic               busy;
  logic               in_idle;
  logic [7:0]         rd_data;
  logic [7:0]         rx_byte;
  logic               receiving;
  logic               rx_done;
  logic               ctrl_ok;
  logic               buf_clr;
  logic               buf_push;
  logic               commit_go;
  logic [SLOTS-1:0]   buf_valid;
  logic               buf_any;
  logic [PAGE_AW-1:0] buf_slot;
  logic [7:0]         buf_data;

  assign in_idle   = phase_q == PH_IDLE;
  assign rx_byte   = {rx_q[6:0], sda_s};
  assign receiving = phase_q == PH_CTRL || phase_q == PH_WADDR || phase_q == PH_WDATA;
  assign rx_done   = ev_scl_rise && receiving && bit_q == 4'd7;
  assign ctrl_ok   = rx_byte[7:4] == DEV_CODE && !busy;
  assign buf_clr   = rx_done && phase_q == PH_WADDR;
  assign buf_push  = rx_done && phase_q == PH_WDATA;
  assign commit_go = ev_stop && phase_q == PH_WDATA && buf_any;

  eep_page_buf #(.PAGE_AW(PAGE_AW), .DW(8)) u_buf (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (buf_clr),
    .base     (rx_byte[PAGE_AW-1:0]),
    .push     (buf_push),
    .din      (rx_byte),
    .rd_slot  (buf_slot),
    .rd_data  (buf_data),
    .valid    (buf_valid),
    .any_valid(buf_any)
  );

  eep_store #(
    .MEM_AW     (MEM_AW),
    .PAGE_AW    (PAGE_AW),
    .DW         (8),
    .BUSY_CYCLES(BUSY_CYCLES)
  ) u_store (
    .clk        (clk),
    .rst_n      (rst_n),
    .commit     (commit_go),
    .commit_page(page_of(addr_q)),
    .buf_valid  (buf_valid),
    .buf_data   (buf_data),
    .buf_slot   (buf_slot),
    .rd_addr    (addr_q),
    .rd_data    (rd_data),
    .busy       (busy)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      bit_q   <= '0;
      rx_q    <= '0;
      tx_q    <= '0;
      addr_q  <= '0;
      blk_q   <= '0;
      rw_q    <= 1'b0;
      ack_q   <= 1'b0;
      pull_q  <= 1'b0;
    end else if (ev_start) begin
      phase_q <= PH_CTRL;
      bit_q   <= '0;
      ack_q   <= 1'b0;
      pull_q  <= 1'b0;
    end else if (ev_stop) begin
      phase_q <= PH_IDLE;
      bit_q   <= '0;
      ack_q   <= 1'b0;
      pull_q  <= 1'b0;
    end else begin
      unique case (phase_q)
        PH_CTRL, PH_WADDR, PH_WDATA: begin
          if (ev_scl_rise) begin
            if (bit_q < 4'd8) begin
              rx_q  <= rx_byte;
              bit_q <= bit_next(bit_q);
              if (bit_q == 4'd7) begin
                if (phase_q == PH_CTRL) begin
                  if (ctrl_ok) begin
                    ack_q <= 1'b1;
                    rw_q  <= rx_byte[0];
                    blk_q <= rx_byte[BLK_W:1];
                  end else begin
                    phase_q <= PH_IDLE;
                    bit_q   <= '0;
                  end
                end else begin
                  ack_q <= 1'b1;
                  if (phase_q == PH_WADDR)
                    addr_q <= join_addr(blk_q, rx_byte);
                end
              end
            end else if (bit_q == 4'd8) begin
              bit_q <= 4'd9;
            end
          end else if (ev_scl_fall) begin
            if (bit_q == 4'd8) begin
              pull_q <= ack_q;
            end else if (bit_q == 4'd9) begin
              pull_q <= 1'b0;
              ack_q  <= 1'b0;
              bit_q  <= '0;
              if (phase_q == PH_CTRL) begin
                if (rw_q) begin
                  phase_q <= PH_READ;
                  tx_q    <= rd_data;
                  pull_q  <= ~rd_data[7];
                end else begin
                  phase_q <= PH_WADDR;
                end
              end else begin
                phase_q <= PH_WDATA;
              end
            end
          end
        end
        PH_READ: begin
          if (ev_scl_rise) begin
            if (bit_q < 4'd8) begin
              bit_q <= bit_next(bit_q);
            end else if (bit_q == 4'd8) begin
              if (!sda_s) begin
                addr_q <= addr_step(addr_q);
                bit_q  <= 4'd9;
              end else begin
                phase_q <= PH_IDLE;
                bit_q   <= '0;
              end
            end
          end else if (ev_scl_fall) begin
            if (bit_q >= 4'd1 && bit_q <= 4'd7) begin
              tx_q   <= {tx_q[6:0], 1'b0};
              pull_q <= ~tx_q[6];
            end else if (bit_q == 4'd8) begin
              pull_q <= 1'b0;
            end else if (bit_q == 4'd9) begin
              tx_q   <= rd_data;
              pull_q <= ~rd_data[7];
              bit_q  <= '0;
            end
          end
        end
        default: begin
          bit_q <= '0;
        end
      endcase
    end
  end

  assign sda_pull_o = pull_q;

endmodule

// File: rtl/eep_checker.sv
module eep_checker (
  input logic clk,
  input logic rst_n,
  input logic sda_pull_o,
  input logic ev_start,
  input logic ev_stop,
  input logic ev_scl_fall,
  input logic busy,
  input logic in_idle
);

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    in_idle |-> !sda_pull_o); // R1

  AST_PULL_ON_LOW_SCL: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_pull_o) |-> $past(ev_scl_fall || ev_start || ev_stop)); // R5

  AST_STOP_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    ev_stop |=> !sda_pull_o); // R11

  AST_BUSY_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !sda_pull_o); // R10

  AST_BUSY_FROM_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(ev_stop)); // R9

endmodule

bind i2c_eeprom_target eep_checker u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .sda_pull_o (sda_pull_o),
  .ev_start   (ev_start),
  .ev_stop    (ev_stop),
  .ev_scl_fall(ev_scl_fall),
  .busy       (busy),
  .in_idle    (in_idle)
);

// File: tb/i2c_eeprom_target_test.sv
`timescale 1ns/1ps
module i2c_eeprom_target_test;

  localparam int Q    = 6;
  localparam int BUSY = 600;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m_low = 1'b0;
  logic sda_pull_o;
  logic sda_line;

  int nchk = 0;
  int nerr = 0;
  logic [7:0] model [1024];

  always #2.5 clk = ~clk;

  assign sda_line = !(sda_m_low || sda_pull_o);

  i2c_eeprom_target #(.BUSY_CYCLES(BUSY)) uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_i     (scl_m),
    .sda_i     (sda_line),
    .sda_pull_o(sda_pull_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start;
    if (!scl_m) begin
      sda_m_low = 1'b0; tick(Q);
      scl_m = 1'b1; tick(Q);
    end
    sda_m_low = 1'b1; tick(Q);
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic bus_stop;
    sda_m_low = 1'b1; tick(Q);
    scl_m = 1'b1; tick(Q);
    sda_m_low = 1'b0; tick(Q);
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      sda_m_low = !b[i]; tick(Q);
      scl_m = 1'b1; tick(2 * Q);
      scl_m = 1'b0; tick(Q);
    end
  endtask

  // ack = line held low both early and late in the ninth high period
  task automatic send_byte(input logic [7:0] b, output bit ackd);
    logic s1, s2;
    send_bits(b, 8);
    sda_m_low = 1'b0; tick(Q);
    scl_m = 1'b1; tick(1);
    s1 = sda_line; tick(2 * Q - 2);
    s2 = sda_line; tick(1);
    scl_m = 1'b0; tick(Q);
    ackd = !s1 && !s2;
  endtask

  task automatic recv_byte(input bit give_ack, output logic [7:0] b);
    sda_m_low = 1'b0;
    b = '0;
    for (int i = 0; i < 8; i++) begin
      tick(Q);
      scl_m = 1'b1; tick(Q);
      b = {b[6:0], sda_line}; tick(Q);
      scl_m = 1'b0; tick(Q);
    end
    sda_m_low = give_ack; tick(Q);
    scl_m = 1'b1; tick(2 * Q);
    scl_m = 1'b0; tick(Q);
    sda_m_low = 1'b0;
  endtask

  function automatic logic [7:0] ctrl(input logic [9:0] a, input bit rd);
    return {4'b1010, 1'b0, a[9:8], rd};
  endfunction

  function automatic logic [7:0] pattern(input int k, input int seed);
    return 8'((k * 37 + seed) & 255);
  endfunction

  // page write: ctrl, address, n data bytes, STOP, then probe busy
  task automatic wr_page(input logic [9:0] a, input int n, input int seed);
    bit ak;
    logic [7:0] d;
    logic [9:0] slot_addr;
    bus_start;
    send_byte(ctrl(a, 1'b0), ak); check(ak, "R2 ctrl ack", ak, 1);
    send_byte(a[7:0], ak);        check(ak, "R3 addr ack", ak, 1);
    for (int k = 0; k < n; k++) begin
      d = pattern(k, seed);
      send_byte(d, ak); check(ak, "R3 data ack", ak, 1);
      slot_addr = {a[9:4], 4'(a[3:0] + 4'(k))}; // R8 slot rule
      model[slot_addr] = d;
    end
    bus_stop;
    check(!sda_pull_o, "R11 released after stop", sda_pull_o, 0);
    bus_start;
    send_byte(ctrl(a, 1'b0), ak); check(!ak, "R10 no ack while busy", ak, 0);
    bus_stop;
    tick(BUSY + 50);
  endtask

  // random read through repeated START, n bytes, last one not acknowledged
  task automatic rd_seq(input logic [9:0] a, input int n);
    bit ak;
    logic [7:0] got;
    logic [9:0] ra;
    bus_start;
    send_byte(ctrl(a, 1'b0), ak); check(ak, "R2 ctrl ack", ak, 1);
    send_byte(a[7:0], ak);        check(ak, "R4 addr ack", ak, 1);
    bus_start;
    send_byte(ctrl(a, 1'b1), ak); check(ak, "R7 read ctrl ack", ak, 1);
    for (int k = 0; k < n; k++) begin
      ra = a + 10'(k);
      recv_byte(k < n - 1, got);
      check(got == model[ra], "R5 read data", got, model[ra]);
    end
    recv_byte(1'b0, got);
    check(got == 8'hFF, "R6 silent after nack", got, 8'hFF);
    bus_stop;
  endtask

  initial begin
    bit ak;
    logic [7:0] got;
    tick(10);
    rst_n = 1'b1;
    tick(20);
    check(!sda_pull_o, "R1 reset release", sda_pull_o, 0);

    // R1: a byte without START gets no ack
    send_bits(8'hA0, 0);
    scl_m = 1'b0; tick(Q);
    send_byte(8'hA0, ak); check(!ak, "R1 no start no ack", ak, 0);
    scl_m = 1'b1; sda_m_low = 1'b0; tick(Q);
    bus_stop;

    // R2: sweep every other device code
    for (int c = 0; c < 16; c++) begin
      if (c != 10) begin
        bus_start;
        send_byte({4'(c), 4'b0000}, ak); check(!ak, "R2 foreign code", ak, 0);
        send_byte(8'h00, ak);           check(!ak, "R2 ignored tail", ak, 0);
        bus_stop;
      end
    end

    // page writes across all block-select values (R4, R8, R9, R10)
    wr_page(10'h000, 16, 3);
    wr_page(10'h153, 16, 11);
    wr_page(10'h3F0, 16, 29);
    wr_page(10'h28A, 5, 71);
    wr_page(10'h105, 20, 90);   // R8 overwrite of oldest slots

    rd_seq(10'h000, 16);
    rd_seq(10'h150, 16);
    rd_seq(10'h100, 16);
    rd_seq(10'h3F8, 12);        // R5 wrap 3FF -> 000
    rd_seq(10'h28A, 5);

    // R9: STOP after only an address, no busy, memory unchanged
    bus_start;
    send_byte(ctrl(10'h005, 1'b0), ak); check(ak, "R9 ctrl", ak, 1);
    send_byte(8'h05, ak);               check(ak, "R9 addr", ak, 1);
    bus_stop;
    bus_start;
    send_byte(ctrl(10'h005, 1'b0), ak); check(ak, "R9 not busy after addr-only", ak, 1);
    bus_stop;

    // R9: STOP after partial data byte
    bus_start;
    send_byte(ctrl(10'h007, 1'b0), ak); check(ak, "R9 ctrl", ak, 1);
    send_byte(8'h07, ak);               check(ak, "R9 addr", ak, 1);
    send_bits(8'h00, 5);
    bus_stop;
    bus_start;
    send_byte(ctrl(10'h007, 1'b0), ak); check(ak, "R9 not busy after partial", ak, 1);
    bus_stop;
    rd_seq(10'h005, 3);

    // R7: START mid data byte aborts, then read from the set address
    bus_start;
    send_byte(ctrl(10'h108, 1'b0), ak); check(ak, "R7 ctrl", ak, 1);
    send_byte(8'h08, ak);               check(ak, "R7 addr", ak, 1);
    send_bits(8'h00, 4);
    bus_start;
    send_byte(ctrl(10'h108, 1'b1), ak); check(ak, "R7 read ctrl", ak, 1);
    recv_byte(1'b0, got);
    check(got == model[10'h108], "R7 read after abort", got, model[10'h108]);
    bus_stop;
    bus_start;
    send_byte(ctrl(10'h108, 1'b0), ak); check(ak, "R7 no commit after abort", ak, 1);
    bus_stop;
    rd_seq(10'h108, 2);

    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    nchk++;
    nerr++;
    $display("FAIL watchdog actual %0d expected %0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end

endmodule